// File: doc/BRIEF.md
# Burst-mode sequencing controller

This block is a clocked controller that runs a burst-mode specification. Each state owns a small set of arcs. An arc pairs an input burst (a set of input edges) with an output burst (a set of output toggles) and a successor state. The controller samples its three inputs, called A, B and C, on every clock. It compares them against the input values it captured when it entered the current state. When every edge of one arc's input burst is present, it toggles that arc's outputs and moves to the successor. The edges may arrive in any order and at any pace.

The specification is a parameter table. There is one entry per state and arc slot. Each entry holds a valid bit, an input edge mask, the edge target levels, an output toggle mask and the next-state index. The default table starts in a state with inputs ABC = 000 and outputs YZ = 01. From there it offers A+ C+ (giving Z-) and A+ B+ (giving Y+ Z-). The two branches rejoin the first state through arcs that lower the inputs again. One of those arcs has an empty output burst.

An input edge that no arc of the current state lists is a protocol violation. It raises a sticky error flag, which only reset clears.

Top module: `bm_controller`

## Requirements
- R1: Synchronous active-low reset sets the outputs to Y=0, Z=1 (burstOut = 2'b10, bit 0 = Y, bit 1 = Z). It clears errFlag, selects state 0 and takes 000 as the captured entry inputs (burstIn bit 0 = A, bit 1 = B, bit 2 = C).
- R2: While no input burst of the current state is complete, burstOut does not change.
- R3: A burst completes whatever the order and spacing of its edges. The output toggles appear on the second rising clock edge after the input carrying the last edge is applied.
- R4: In state 0, the burst A+ C+ clears Z (burstOut becomes 00). The burst A+ B+ sets Y and clears Z (burstOut becomes 01).
- R5: An arc with an empty output burst still moves the controller. In the default table, C- after A+ C+ sets Z again, and the following A- returns to state 0 with no output change.
- R6: When several bursts of a state complete in the same cycle, the arc in the lowest slot fires. With the default table, ABC rising together in state 0 gives burstOut = 00.
- R7: An input edge named by no arc of the current state sets errFlag. errFlag then stays set, even after the input returns, until reset. The outputs are not altered by such an edge.
- R8: Edges are measured against the inputs captured on entry to the state. An input that changes and then returns before the burst completes does not count toward that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| burstIn | input | 3 | Inputs: bit 0 A, bit 1 B, bit 2 C |
| burstOut | output | 2 | Outputs: bit 0 Y, bit 1 Z |
| errFlag | output | 1 | Sticky flag for an unexpected input edge |

## Verification
The bench builds the block with its default parameters:
- five states with up to two arcs each;
- entry inputs 000 and outputs YZ = 01.

This table reaches every kind of arc:
- a two-way choice in the first state;
- single-edge bursts;
- a burst that mixes a rising and a falling edge;
- an empty output burst.

Because the two bursts of state 0 share A+, one stimulus can complete both in the same cycle to exercise lowest-slot priority. The single-arc state entered after A+ B+ (expecting B- and C+) gives an edge on A that no arc names.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int BM_IN_W    = 3;
  localparam int BM_OUT_W   = 2;
  localparam int BM_STATES  = 5;
  localparam int BM_ARCS    = 2;
  localparam int BM_STATE_W = $clog2(BM_STATES);

  typedef struct packed {
    logic                  valid;
    logic [BM_IN_W-1:0]    mask;
    logic [BM_IN_W-1:0]    dir;
    logic [BM_OUT_W-1:0]   toggle;
    logic [BM_STATE_W-1:0] next;
  } arc_t;

  typedef arc_t [BM_STATES*BM_ARCS-1:0] arc_table_t;

  typedef struct packed {
    logic                  fire;
    logic                  errSet;
    logic [BM_OUT_W-1:0]   toggle;
    logic [BM_STATE_W-1:0] nextState;
  } strobe_t;

  function automatic arc_t mkArc(input logic [BM_IN_W-1:0] mask,
                                 input logic [BM_IN_W-1:0] dir,
                                 input logic [BM_OUT_W-1:0] toggle,
                                 input int unsigned next);
    arc_t a;
    a.valid  = 1'b1;
    a.mask   = mask;
    a.dir    = dir;
    a.toggle = toggle;
    a.next   = BM_STATE_W'(next);
    return a;
  endfunction

  // Input bits: 0=A 1=B 2=C. Output bits: 0=Y 1=Z.
  function automatic arc_table_t defaultTable();
    arc_table_t t;
    t = '0;
    t[0*BM_ARCS+0] = mkArc(3'b101, 3'b101, 2'b10, 1); // A+ C+ / Z-
    t[0*BM_ARCS+1] = mkArc(3'b011, 3'b011, 2'b11, 2); // A+ B+ / Y+ Z-
    t[1*BM_ARCS+0] = mkArc(3'b100, 3'b000, 2'b10, 3); // C- / Z+
    t[2*BM_ARCS+0] = mkArc(3'b110, 3'b100, 2'b10, 4); // B- C+ / Z+
    t[3*BM_ARCS+0] = mkArc(3'b001, 3'b000, 2'b00, 0); // A- / none
    t[4*BM_ARCS+0] = mkArc(3'b101, 3'b000, 2'b01, 0); // A- C- / Y-
    return t;
  endfunction
endpackage

// File: rtl/bm_arc_match.sv
module bm_arc_match
  import bm_pkg::*;
(
  input  arc_t               arc,
  input  logic [BM_IN_W-1:0] inSmp,
  input  logic [BM_IN_W-1:0] entryVal,
  output logic               complete,
  output logic [BM_IN_W-1:0] claimed
);
  logic [BM_IN_W-1:0] moved;

  always_comb begin
    moved    = inSmp ^ entryVal;
    claimed  = arc.valid ? arc.mask : '0;
    complete = arc.valid && (arc.mask != '0) &&
               ((moved & arc.mask) == arc.mask) &&
               ((inSmp & arc.mask) == (arc.dir & arc.mask));
  end
endmodule

// File: rtl/bm_control.sv
module bm_control
  import bm_pkg::*;
#(
  parameter int         NUM_STATES     = BM_STATES,
  parameter int         ARCS_PER_STATE = BM_ARCS,
  parameter arc_table_t ARC_TABLE      = defaultTable()
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BM_STATE_W-1:0] state,
  input  logic [BM_IN_W-1:0]    inSmp,
  input  logic [BM_IN_W-1:0]    entryVal,
  output strobe_t               strobe
);
  arc_t               curArc   [ARCS_PER_STATE];
  logic               complete [ARCS_PER_STATE];
  logic [BM_IN_W-1:0] claimed  [ARCS_PER_STATE];

  for (genvar k = 0; k < ARCS_PER_STATE; k++) begin : g_arc
    always_comb begin
      if (int'(state) < NUM_STATES)
        curArc[k] = ARC_TABLE[int'(state)*ARCS_PER_STATE + k];
      else
        curArc[k] = '0;
    end

    bm_arc_match u_match (
      .arc      (curArc[k]),
      .inSmp    (inSmp),
      .entryVal (entryVal),
      .complete (complete[k]),
      .claimed  (claimed[k])
    );
  end

  logic [BM_IN_W-1:0] claimedAll;
  logic               found;

  always_comb begin
    strobe     = '0;
    claimedAll = '0;
    found      = 1'b0;
    for (int k = 0; k < ARCS_PER_STATE; k++) begin
      claimedAll = claimedAll | claimed[k];
      if (complete[k] && !found) begin
        found            = 1'b1;
        strobe.fire      = 1'b1;
        strobe.toggle    = curArc[k].toggle;
        strobe.nextState = curArc[k].next;
      end
    end
    strobe.errSet = |((inSmp ^ entryVal) & ~claimedAll);
  end

  // R3
  fire_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> (inSmp != entryVal));

  // R7
  err_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errSet |-> (inSmp != entryVal));

  // R5
  next_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> (int'(strobe.nextState) < NUM_STATES));
endmodule

// File: rtl/bm_datapath.sv
module bm_datapath
  import bm_pkg::*;
#(
  parameter logic [BM_IN_W-1:0]  INIT_IN  = '0,
  parameter logic [BM_OUT_W-1:0] INIT_OUT = 2'b10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BM_IN_W-1:0]    burstIn,
  input  strobe_t               strobe,
  output logic [BM_STATE_W-1:0] state,
  output logic [BM_IN_W-1:0]    inSmp,
  output logic [BM_IN_W-1:0]    entryVal,
  output logic [BM_OUT_W-1:0]   outReg,
  output logic                  errReg
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSmp    <= INIT_IN;
      entryVal <= INIT_IN;
      state    <= '0;
      outReg   <= INIT_OUT;
      errReg   <= 1'b0;
    end else begin
      inSmp <= burstIn;
      if (strobe.fire) begin
        state    <= strobe.nextState;
        outReg   <= outReg ^ strobe.toggle;
        entryVal <= inSmp;
      end
      if (strobe.errSet) errReg <= 1'b1;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> $stable(outReg));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReg |=> errReg);

  // R8
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> $stable(entryVal));
endmodule

// File: rtl/bm_controller.sv
module bm_controller
  import bm_pkg::*;
#(
  parameter int                  NUM_STATES     = BM_STATES,
  parameter int                  ARCS_PER_STATE = BM_ARCS,
  parameter arc_table_t          ARC_TABLE      = defaultTable(),
  parameter logic [BM_IN_W-1:0]  INIT_IN        = 3'b000,
  parameter logic [BM_OUT_W-1:0] INIT_OUT       = 2'b10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BM_IN_W-1:0]  burstIn,
  output logic [BM_OUT_W-1:0] burstOut,
  output logic                errFlag
);
  strobe_t               strobe;
  logic [BM_STATE_W-1:0] state;
  logic [BM_IN_W-1:0]    inSmp;
  logic [BM_IN_W-1:0]    entryVal;

  bm_control #(
    .NUM_STATES     (NUM_STATES),
    .ARCS_PER_STATE (ARCS_PER_STATE),
    .ARC_TABLE      (ARC_TABLE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .state    (state),
    .inSmp    (inSmp),
    .entryVal (entryVal),
    .strobe   (strobe)
  );

  bm_datapath #(
    .INIT_IN  (INIT_IN),
    .INIT_OUT (INIT_OUT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .burstIn  (burstIn),
    .strobe   (strobe),
    .state    (state),
    .inSmp    (inSmp),
    .entryVal (entryVal),
    .outReg   (burstOut),
    .errReg   (errFlag)
  );
endmodule

// File: tb/tb_bm_controller.sv
module tb_bm_controller;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] burstIn = 3'b000;
  logic [1:0] burstOut;
  logic       errFlag;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bm_controller dut (
    .clk      (clk),
    .rstN     (rstN),
    .burstIn  (burstIn),
    .burstOut (burstOut),
    .errFlag  (errFlag)
  );

  typedef struct packed {
    logic [2:0] in;
    logic [1:0] expOut;
    logic [3:0] gap;
    logic [3:0] tag;
  } vec_t;

  // Output encoding: {Z,Y}. Input encoding: {C,B,A}.
  localparam vec_t VECS [10] = '{
    '{3'b001, 2'b10, 4'd0, 4'd2}, // R2 A+ alone
    '{3'b101, 2'b00, 4'd3, 4'd4}, // R4 A+ C+ gives Z-
    '{3'b001, 2'b10, 4'd0, 4'd5}, // R5 C- gives Z+
    '{3'b000, 2'b10, 4'd0, 4'd5}, // R5 A-, empty output burst
    '{3'b010, 2'b10, 4'd5, 4'd3}, // R3 B+ first, long wait
    '{3'b011, 2'b01, 4'd0, 4'd4}, // R4 A+ B+ gives Y+ Z-
    '{3'b111, 2'b01, 4'd0, 4'd2}, // R2 C+ half of burst
    '{3'b101, 2'b11, 4'd0, 4'd3}, // R3 B- completes mixed burst
    '{3'b100, 2'b11, 4'd2, 4'd2}, // R2 A- half of burst
    '{3'b000, 2'b10, 4'd0, 4'd3}  // R3 C- gives Y-, back to state 0
  };

  function automatic string tagName(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v, input int gap);
    @(negedge clk);
    burstIn = v;
    repeat (2 + gap) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    burstIn = 3'b000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset out", burstOut, 2'b10);
    check("R1", "reset err", {1'b0, errFlag}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      drive(VECS[i].in, int'(VECS[i].gap));
      check(tagName(int'(VECS[i].tag)), $sformatf("vector %0d out", i),
            burstOut, VECS[i].expOut);
      check(tagName(int'(VECS[i].tag)), $sformatf("vector %0d err", i),
            {1'b0, errFlag}, 2'b00);
    end

    // R3: timing, no change one cycle after the completing edge
    @(negedge clk);
    burstIn = 3'b101;
    @(negedge clk);
    check("R3", "one cycle after last edge", burstOut, 2'b10);
    @(negedge clk);
    check("R3", "two cycles after last edge", burstOut, 2'b00);
    drive(3'b001, 0);
    drive(3'b000, 0);
    check("R5", "back in state 0", burstOut, 2'b10);

    // R8: A rises and falls, then C rises: no burst complete
    drive(3'b001, 0);
    drive(3'b000, 0);
    drive(3'b100, 0);
    check("R8", "reverted edge not counted", burstOut, 2'b10);
    check("R8", "no error on revert", {1'b0, errFlag}, 2'b00);
    drive(3'b101, 0);
    check("R8", "burst completes after A+ again", burstOut, 2'b00);

    // R1: reset mid-run, then a burst from the reset entry values
    doReset();
    check("R1", "out after reset", burstOut, 2'b10);
    drive(3'b011, 0);
    check("R1", "entry inputs 000 after reset", burstOut, 2'b01);

    // R6: all inputs rise together in state 0, lowest slot wins
    doReset();
    drive(3'b111, 0);
    check("R6", "simultaneous bursts", burstOut, 2'b00);

    // R7: A falls in the state waiting for B- C+
    doReset();
    drive(3'b011, 0);
    check("R7", "entered state 2", burstOut, 2'b01);
    check("R7", "no error before", {1'b0, errFlag}, 2'b00);
    drive(3'b010, 0);
    check("R7", "error raised", {1'b0, errFlag}, 2'b01);
    check("R7", "outputs untouched", burstOut, 2'b01);
    drive(3'b011, 0);
    check("R7", "error sticky", {1'b0, errFlag}, 2'b01);
    drive(3'b101, 0);
    check("R7", "still sequencing", burstOut, 2'b11);
    doReset();
    check("R1", "reset clears error", {1'b0, errFlag}, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule